// File: doc/BRIEF.md
# Context-Tagged Fully Associative Address Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for 4 KB pages. It keeps 16 translations, and any page may sit in any slot. Each slot holds a page number, a frame number, an 8-bit address-space context tag, three access-right bits, a dirty bit and a valid bit. A lookup compares the page number and the context against every slot in parallel. In the same cycle it reports a hit together with the physical address, a miss, or a permission fault, so the pipeline can cancel the access before write-back. Entries from several processes can be present together, so a context switch does not need a flush.

The miss handler installs entries through a fill port. A fill goes to the lowest free slot. When every slot is in use, it goes to the slot named by a round-robin pointer. Two flush inputs clear either every entry or only the entries of one context. A permitted write marks its entry dirty, and later lookups report that bit.

Top module: `tlb_ctx`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the replacement pointer starts at slot 0.
- R2: A hit needs a valid entry whose stored page number equals vaddr[31:12] and whose stored context equals the lookup context. The same page under another context misses.
- R3: On a hit the physical address is {frame, vaddr[11:0]}. On a miss or a fault the physical address is 0.
- R4: Results are combinational, in the same cycle as the request. While the request is low, hit, miss, fault, dirty and the address are all 0. While it is high, exactly one of hit, miss and fault is 1.
- R5: Access type 00 is read, 01 is write and 10 is execute, checked against permission bits 0, 1 and 2. Type 11 always faults. A matching entry that lacks the right produces a fault instead of a hit, and a fault leaves the dirty bit unchanged.
- R6: A permitted write hit sets the dirty bit of its entry at the clock edge. The dirty output shows the stored bit of the matching entry on a hit or a fault, and shows the value from before the update in that same cycle.
- R7: A fill goes to the lowest-numbered invalid slot and leaves the pointer alone. If no slot is invalid, the fill goes to the pointer's slot and the pointer then advances by one modulo 16. A fill overrides a dirty update to the same slot in the same cycle.
- R8: The global flush clears all valid bits in one cycle. A fill in the same cycle is ignored.
- R9: The context flush clears only entries whose context equals the flush context. A fill in the same cycle is ignored.
- R10: If several entries match, the lowest-numbered one supplies the frame, the rights and the dirty bit, and is the one marked dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 32 | Virtual address |
| lkp_ctx_i | input | 8 | Current address-space context |
| lkp_acc_i | input | 2 | Access type: 00 read, 01 write, 10 execute |
| lkp_paddr_o | output | 32 | Physical address on hit |
| lkp_hit_o | output | 1 | Translation found and permitted |
| lkp_miss_o | output | 1 | No matching entry |
| lkp_fault_o | output | 1 | Matching entry forbids the access |
| lkp_dirty_o | output | 1 | Dirty bit of the matching entry |
| fill_valid_i | input | 1 | Install an entry |
| fill_vpn_i | input | 20 | Page number to install |
| fill_pfn_i | input | 20 | Frame number to install |
| fill_ctx_i | input | 8 | Context of the new entry |
| fill_perm_i | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| fill_dirty_i | input | 1 | Initial dirty bit |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_ctx_i | input | 1 | Invalidate entries of one context |
| flush_ctx_id_i | input | 8 | Context to invalidate |

## Verification
The round-robin path and duplicate matches are the hardest states to reach. Both need every slot to be valid, and the second also needs the same page and context installed twice. The directed part fills all 16 slots and then keeps filling, which moves the pointer over slots 0 to 4. It places a duplicate pair in adjacent replaced slots to show that the lower one wins. The random part uses only eight page numbers and three contexts, so hits, duplicates, overlapping flushes and fills, and writes that coincide with fills all occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  localparam int unsigned PERM_W = 3;
  localparam int unsigned PERM_R = 0;
  localparam int unsigned PERM_W_BIT = 1;
  localparam int unsigned PERM_X = 2;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned N     = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned CTX_W = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [N-1:0][CTX_W-1:0] ctx_i,
  input  logic [VPN_W-1:0]        key_vpn_i,
  input  logic [CTX_W-1:0]        key_ctx_i,
  output logic                    match_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (ctx_i[g] == key_ctx_i);
  end

  // lowest index wins on duplicate matches
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx_o = IDX_W'(i);
    end
  end

  assign match_o = |hit_vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [IDX_W-1:0] rr_i,
  output logic             free_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign free_o = ~&valid_i;
  assign idx_o  = free_o ? free_idx : rr_i;
endmodule

// File: rtl/tlb_ctx.sv
module tlb_ctx #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned CTX_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 lkp_valid_i,
  input  logic [VA_W-1:0]      lkp_vaddr_i,
  input  logic [CTX_W-1:0]     lkp_ctx_i,
  input  logic [1:0]           lkp_acc_i,
  output logic [PA_W-1:0]      lkp_paddr_o,
  output logic                 lkp_hit_o,
  output logic                 lkp_miss_o,
  output logic                 lkp_fault_o,
  output logic                 lkp_dirty_o,
  input  logic                 fill_valid_i,
  input  logic [VA_W-PAGE_W-1:0] fill_vpn_i,
  input  logic [PA_W-PAGE_W-1:0] fill_pfn_i,
  input  logic [CTX_W-1:0]     fill_ctx_i,
  input  logic [2:0]           fill_perm_i,
  input  logic                 fill_dirty_i,
  input  logic                 flush_all_i,
  input  logic                 flush_ctx_i,
  input  logic [CTX_W-1:0]     flush_ctx_id_i
);
  import tlb_pkg::*;

  localparam int unsigned VPN_W = VA_W - PAGE_W;
  localparam int unsigned PFN_W = PA_W - PAGE_W;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             dirty_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][CTX_W-1:0]  ctx_q;
  logic [ENTRIES-1:0][PERM_W-1:0] perm_q;
  logic [IDX_W-1:0]               rr_q;

  logic             match;
  logic [IDX_W-1:0] m_idx;
  logic             vic_free;
  logic [IDX_W-1:0] vic_idx;
  logic             allowed;
  logic             wr_ok;
  logic             any_flush;

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) i_cam (
    .valid_i   (valid_q),
    .vpn_i     (vpn_q),
    .ctx_i     (ctx_q),
    .key_vpn_i (lkp_vaddr_i[VA_W-1:PAGE_W]),
    .key_ctx_i (lkp_ctx_i),
    .match_o   (match),
    .idx_o     (m_idx)
  );

  tlb_victim #(.N(ENTRIES)) i_victim (
    .valid_i (valid_q),
    .rr_i    (rr_q),
    .free_o  (vic_free),
    .idx_o   (vic_idx)
  );

  always_comb begin
    unique case (acc_e'(lkp_acc_i))
      ACC_READ:  allowed = perm_q[m_idx][PERM_R];
      ACC_WRITE: allowed = perm_q[m_idx][PERM_W_BIT];
      ACC_EXEC:  allowed = perm_q[m_idx][PERM_X];
      default:   allowed = 1'b0;
    endcase
  end

  assign lkp_hit_o   = lkp_valid_i && match && allowed;
  assign lkp_fault_o = lkp_valid_i && match && !allowed;
  assign lkp_miss_o  = lkp_valid_i && !match;
  assign lkp_dirty_o = lkp_valid_i && match && dirty_q[m_idx];
  assign lkp_paddr_o = lkp_hit_o ? {pfn_q[m_idx], lkp_vaddr_i[PAGE_W-1:0]} : '0;

  assign wr_ok     = lkp_hit_o && (lkp_acc_i == ACC_WRITE);
  assign any_flush = flush_all_i || flush_ctx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      vpn_q   <= '0;
      pfn_q   <= '0;
      ctx_q   <= '0;
      perm_q  <= '0;
      rr_q    <= '0;
    end else begin
      if (wr_ok) dirty_q[m_idx] <= 1'b1;
      if (flush_all_i) begin
        valid_q <= '0;
      end else if (flush_ctx_i) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (ctx_q[i] == flush_ctx_id_i) valid_q[i] <= 1'b0;
        end
      end else if (fill_valid_i) begin
        valid_q[vic_idx] <= 1'b1;
        dirty_q[vic_idx] <= fill_dirty_i;   // overrides same-cycle write mark
        vpn_q[vic_idx]   <= fill_vpn_i;
        pfn_q[vic_idx]   <= fill_pfn_i;
        ctx_q[vic_idx]   <= fill_ctx_i;
        perm_q[vic_idx]  <= fill_perm_i;
        if (!vic_free) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  logic unused_flush;
  assign unused_flush = any_flush;
endmodule

// File: rtl/tlb_ctx_chk.sv
module tlb_ctx_chk #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned CTX_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_valid_i,
  input logic [VA_W-1:0]  lkp_vaddr_i,
  input logic [CTX_W-1:0] lkp_ctx_i,
  input logic [1:0]       lkp_acc_i,
  input logic [PA_W-1:0]  lkp_paddr_o,
  input logic             lkp_hit_o,
  input logic             lkp_miss_o,
  input logic             lkp_fault_o,
  input logic             lkp_dirty_o,
  input logic             fill_valid_i,
  input logic             flush_all_i,
  input logic             flush_ctx_i
);
  p_one_result_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> $countones({lkp_hit_o, lkp_miss_o, lkp_fault_o}) == 1);

  p_quiet_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !(lkp_hit_o || lkp_miss_o || lkp_fault_o || lkp_dirty_o));

  p_offset_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_paddr_o[PAGE_W-1:0] == lkp_vaddr_i[PAGE_W-1:0]);

  p_no_addr_off_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_hit_o |-> lkp_paddr_o == '0);

  p_flush_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (!lkp_valid_i || lkp_miss_o));

  p_write_marks_dirty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_hit_o && lkp_acc_i == 2'b01 && !fill_valid_i && !flush_all_i && !flush_ctx_i)
    |=> (!(lkp_valid_i && !lkp_miss_o
           && lkp_vaddr_i[VA_W-1:PAGE_W] == $past(lkp_vaddr_i[VA_W-1:PAGE_W])
           && lkp_ctx_i == $past(lkp_ctx_i)) || lkp_dirty_o));

  p_fault_no_dirty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_fault_o && !fill_valid_i && !flush_all_i && !flush_ctx_i)
    |=> (!(lkp_valid_i && !lkp_miss_o
           && lkp_vaddr_i[VA_W-1:PAGE_W] == $past(lkp_vaddr_i[VA_W-1:PAGE_W])
           && lkp_ctx_i == $past(lkp_ctx_i)) || lkp_dirty_o == $past(lkp_dirty_o)));
endmodule

bind tlb_ctx tlb_ctx_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .CTX_W(CTX_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_valid_i (lkp_valid_i),
  .lkp_vaddr_i (lkp_vaddr_i),
  .lkp_ctx_i   (lkp_ctx_i),
  .lkp_acc_i   (lkp_acc_i),
  .lkp_paddr_o (lkp_paddr_o),
  .lkp_hit_o   (lkp_hit_o),
  .lkp_miss_o  (lkp_miss_o),
  .lkp_fault_o (lkp_fault_o),
  .lkp_dirty_o (lkp_dirty_o),
  .fill_valid_i(fill_valid_i),
  .flush_all_i (flush_all_i),
  .flush_ctx_i (flush_ctx_i)
);

// File: tb/test_tlb_ctx.sv
`timescale 1ns/1ps
module test_tlb_ctx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [31:0] lkp_vaddr_i = '0;
  logic [7:0]  lkp_ctx_i = '0;
  logic [1:0]  lkp_acc_i = '0;
  logic [31:0] lkp_paddr_o;
  logic        lkp_hit_o, lkp_miss_o, lkp_fault_o, lkp_dirty_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_pfn_i = '0;
  logic [7:0]  fill_ctx_i = '0;
  logic [2:0]  fill_perm_i = '0;
  logic        fill_dirty_i = 1'b0;
  logic        flush_all_i = 1'b0;
  logic        flush_ctx_i = 1'b0;
  logic [7:0]  flush_ctx_id_i = '0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk_i = ~clk_i;

  tlb_ctx i_tlb_ctx (.*);

  // reference model
  logic        m_val [16];
  logic        m_dty [16];
  logic [19:0] m_vpn [16];
  logic [19:0] m_pfn [16];
  logic [7:0]  m_ctx [16];
  logic [2:0]  m_prm [16];
  int          m_rr;

  function automatic int find_match(logic [19:0] vpn, logic [7:0] ctx);
    for (int i = 0; i < 16; i++)
      if (m_val[i] && m_vpn[i] == vpn && m_ctx[i] == ctx) return i;
    return -1;
  endfunction

  function automatic logic perm_ok(int idx, logic [1:0] acc);
    case (acc)
      2'b00: return m_prm[idx][0];
      2'b01: return m_prm[idx][1];
      2'b10: return m_prm[idx][2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin
      m_val[i] = 0; m_dty[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_ctx[i] = 0; m_prm[i] = 0;
    end
    m_rr = 0;
  endtask

  task automatic model_clock();
    int mi;
    int v;
    mi = find_match(lkp_vaddr_i[31:12], lkp_ctx_i);
    if (lkp_valid_i && mi >= 0 && lkp_acc_i == 2'b01 && perm_ok(mi, lkp_acc_i)) m_dty[mi] = 1;
    if (flush_all_i) begin
      for (int i = 0; i < 16; i++) m_val[i] = 0;
    end else if (flush_ctx_i) begin
      for (int i = 0; i < 16; i++) if (m_ctx[i] == flush_ctx_id_i) m_val[i] = 0;
    end else if (fill_valid_i) begin
      v = -1;
      for (int i = 0; i < 16; i++) if (!m_val[i] && v < 0) v = i;
      if (v < 0) begin v = m_rr; m_rr = (m_rr + 1) % 16; end
      m_val[v] = 1; m_dty[v] = fill_dirty_i; m_vpn[v] = fill_vpn_i;
      m_pfn[v] = fill_pfn_i; m_ctx[v] = fill_ctx_i; m_prm[v] = fill_perm_i;
    end
  endtask

  task automatic idle();
    lkp_valid_i = 0; fill_valid_i = 0; flush_all_i = 0; flush_ctx_i = 0;
  endtask

  // inputs set in the low phase; compare, then advance model at the edge
  task automatic step(input string tag);
    int mi;
    logic e_hit, e_miss, e_flt, e_dty;
    logic [31:0] e_pa;
    #1;
    mi = find_match(lkp_vaddr_i[31:12], lkp_ctx_i);
    e_hit = 0; e_miss = 0; e_flt = 0; e_dty = 0; e_pa = '0;
    if (lkp_valid_i) begin
      if (mi < 0) e_miss = 1;
      else begin
        e_dty = m_dty[mi];
        if (perm_ok(mi, lkp_acc_i)) begin e_hit = 1; e_pa = {m_pfn[mi], lkp_vaddr_i[11:0]}; end
        else e_flt = 1;
      end
    end
    n_tests++;
    if ({lkp_hit_o, lkp_miss_o, lkp_fault_o, lkp_dirty_o} !== {e_hit, e_miss, e_flt, e_dty}
        || lkp_paddr_o !== e_pa) begin
      n_fail++;
      $display("FAIL %s: hmfd=%b%b%b%b pa=%h expected hmfd=%b%b%b%b pa=%h", tag,
               lkp_hit_o, lkp_miss_o, lkp_fault_o, lkp_dirty_o, lkp_paddr_o,
               e_hit, e_miss, e_flt, e_dty, e_pa);
    end
    @(posedge clk_i);
    model_clock();
    @(negedge clk_i);
    idle();
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] ctx, input logic [1:0] acc,
                      input string tag);
    lkp_valid_i = 1; lkp_vaddr_i = va; lkp_ctx_i = ctx; lkp_acc_i = acc;
    step(tag);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn, input logic [7:0] ctx,
                      input logic [2:0] perm, input string tag);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_pfn_i = pfn; fill_ctx_i = ctx;
    fill_perm_i = perm; fill_dirty_i = 0;
    step(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    #12 rst_ni = 1'b1;
    @(negedge clk_i);

    step("R4 idle outputs zero");
    look(32'h1234_5678, 8'd1, 2'b00, "R1 miss after reset");
    fill(20'h12345, 20'hABCDE, 8'd1, 3'b111, "R7 fill free slot");
    look(32'h1234_5678, 8'd1, 2'b00, "R3 R2 hit translates");
    look(32'h1234_5FFF, 8'd2, 2'b00, "R2 other context misses");
    fill(20'h00777, 20'h0BEEF, 8'd1, 3'b001, "R7 fill read-only");
    look(32'h0077_7010, 8'd1, 2'b01, "R5 write fault");
    look(32'h0077_7010, 8'd1, 2'b10, "R5 exec fault");
    look(32'h0077_7010, 8'd1, 2'b11, "R5 reserved type faults");
    look(32'h0077_7010, 8'd1, 2'b00, "R5 R6 fault left dirty clear");
    look(32'h1234_5000, 8'd1, 2'b01, "R6 write hit old dirty");
    look(32'h1234_5000, 8'd1, 2'b00, "R6 dirty now set");
    fill(20'h00055, 20'h00066, 8'd2, 3'b111, "R7 fill ctx2");
    flush_ctx_i = 1; flush_ctx_id_i = 8'd1;
    fill_valid_i = 1; fill_vpn_i = 20'h00099; fill_ctx_i = 8'd1; fill_perm_i = 3'b111;
    step("R9 context flush with fill");
    look(32'h1234_5000, 8'd1, 2'b00, "R9 ctx1 entry gone");
    look(32'h0009_9000, 8'd1, 2'b00, "R9 fill ignored during flush");
    look(32'h0005_5ABC, 8'd2, 2'b00, "R9 ctx2 entry kept");
    flush_all_i = 1; fill_valid_i = 1; fill_vpn_i = 20'h00088; fill_ctx_i = 8'd2;
    fill_perm_i = 3'b111;
    step("R8 global flush with fill");
    look(32'h0005_5000, 8'd2, 2'b00, "R8 all entries gone");
    look(32'h0008_8000, 8'd2, 2'b00, "R8 fill ignored");

    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00A00 + 20'(i), 8'd3, 3'b111, "R7 fill all");
    look(32'h0010_F123, 8'd3, 2'b00, "R7 last slot hit");
    fill(20'h00200, 20'h00B00, 8'd3, 3'b111, "R7 round robin slot 0");
    look(32'h0010_0000, 8'd3, 2'b00, "R7 slot 0 evicted");
    look(32'h0020_0444, 8'd3, 2'b00, "R7 new entry hit");
    fill(20'h00201, 20'h00B01, 8'd3, 3'b111, "R7 round robin slot 1");
    look(32'h0010_1000, 8'd3, 2'b00, "R7 slot 1 evicted");
    fill(20'h00300, 20'h00C01, 8'd3, 3'b111, "R10 first duplicate");
    fill(20'h00300, 20'h00C02, 8'd3, 3'b001, "R10 second duplicate");
    look(32'h0030_0abc, 8'd3, 2'b01, "R10 lowest entry used");
    look(32'h0030_0abc, 8'd3, 2'b00, "R10 lowest entry dirty");
    look(32'h0010_4000, 8'd3, 2'b00, "R7 slot 4 still present");

    for (int n = 0; n < 4000; n++) begin
      lkp_valid_i = ($urandom % 5) != 0;
      lkp_vaddr_i = {17'h0, 3'($urandom), 12'($urandom)};
      lkp_ctx_i   = 8'($urandom % 3);
      lkp_acc_i   = 2'($urandom);
      fill_valid_i = ($urandom % 4) == 0;
      fill_vpn_i  = {17'h0, 3'($urandom)};
      fill_pfn_i  = 20'($urandom);
      fill_ctx_i  = 8'($urandom % 3);
      fill_perm_i = 3'($urandom);
      fill_dirty_i = 1'($urandom);
      flush_all_i = ($urandom % 100) == 0;
      flush_ctx_i = ($urandom % 40) == 0;
      flush_ctx_id_i = 8'($urandom % 3);
      step("R2 R5 R6 R7 R10 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule